// File: doc/BRIEF.md
# Serial PLL Configuration Register with IF Power Control

This block takes 24-bit control words from a three-wire serial load port and writes each one into the register that its low address nibble selects. Bits enter MSB first on rising edges of the serial clock. A rising edge on the latch-enable line commits the word. The serial lines are slow compared with the system clock. They are synchronized and edge-detected in the system clock domain.

Three registers are held. The first is the IF reference divider register, which holds the divider value, a charge-pump gain field and an access field. The second is a power register, which holds the stored IF power-down bit and an auto-power-up enable. The third is a general register 0 with a 20-bit payload. If auto-power-up is enabled, any write to register 0 clears the stored power-down bit. The chip-enable pin has top priority: while it is low, the IF PLL is held in power-down and its charge pump is put in tristate.

Top module: `pll_cfg_regs`

## Requirements
- R1: Serial data is sampled on each rising edge of `sclk_i` and shifted in MSB first. The last 24 bits received before a rising edge of `le_i` form the committed word.
- R2: The word's bits 3:0 select the target register. Code 4'b0111 writes the divider register: bits 15:4 go to `if_r_o`, bits 19:16 go to `cp_gain_o` and bits 23:20 go to `access_o`.
- R3: A divider-register write whose bits 15:4 are below 3 leaves `if_r_o` unchanged and sets `bad_r_o` to 1. It still updates `cp_gain_o` and `access_o`. A write with a value of 3 or more (up to 4095) is accepted and clears `bad_r_o`.
- R4: Code 4'b0001 writes the power register. Bit 4 is the stored IF power-down bit (1 = down) and bit 5 is the auto-power-up enable.
- R5: Code 4'b0000 writes register 0: bits 23:4 go to `r0_data_o`. If auto-power-up is enabled at that moment, the stored power-down bit is cleared.
- R6: `pd_o` is 1 when `ce_i` is low or the stored power-down bit is 1, and 0 otherwise. `cp_tri_o` always equals `pd_o`.
- R7: After reset, all register fields, `bad_r_o`, the stored power-down bit and the auto-power-up enable are 0. `pd_o` is 1 while `ce_i` is low.
- R8: A word with any other address code changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial load clock |
| sdata_i | input | 1 | Serial load data |
| le_i | input | 1 | Latch enable; a rising edge commits the word |
| ce_i | input | 1 | Chip enable; low forces power-down |
| if_r_o | output | 12 | IF reference divider value |
| cp_gain_o | output | 4 | Charge-pump gain field |
| access_o | output | 4 | Access field |
| r0_data_o | output | 20 | Register 0 payload |
| bad_r_o | output | 1 | The last divider write was rejected |
| pd_o | output | 1 | IF PLL power-down |
| cp_tri_o | output | 1 | Charge-pump tristate enable |

## Verification
The assertions assume that `sclk_i`, `sdata_i` and `le_i` each hold a level for at least three system clocks, so the synchronizers catch every edge. They also assume that `sdata_i` is already stable when `sclk_i` rises. The bench drives each serial level for three clocks and changes data only while the serial clock is low. It raises latch enable only after a full 24-bit word. Under these conditions each latch edge produces exactly one write strobe, and the stored divider value is never seen below 3 after its first accepted write.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  typedef enum logic [3:0] {
    ADDR_R0  = 4'b0000,
    ADDR_PWR = 4'b0001,
    ADDR_DIV = 4'b0111
  } addr_e;

  localparam int PWR_PD_BIT = 4;
  localparam int PWR_AU_BIT = 5;
endpackage

// File: rtl/serial_shift.sv
module serial_shift #(
  parameter int WORD_W = 24,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              le_i,
  output logic [WORD_W-1:0] word_o,
  output logic              latch_o
);
  logic [SYNC_N-1:0] sclk_q, sdat_q, le_q;
  logic              sclk_prev, le_prev;
  logic [WORD_W-1:0] sr_q;

  // synchronizer chains, stage 0 first
  for (genvar i = 0; i < SYNC_N; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) {sclk_q[0], sdat_q[0], le_q[0]} <= '0;
        else         {sclk_q[0], sdat_q[0], le_q[0]} <= {sclk_i, sdata_i, le_i};
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) {sclk_q[i], sdat_q[i], le_q[i]} <= '0;
        else         {sclk_q[i], sdat_q[i], le_q[i]} <= {sclk_q[i-1], sdat_q[i-1], le_q[i-1]};
    end
  end

  logic sclk_rise;
  assign sclk_rise = sclk_q[SYNC_N-1] & ~sclk_prev;
  assign latch_o   = le_q[SYNC_N-1] & ~le_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev <= 1'b0;
      le_prev   <= 1'b0;
      sr_q      <= '0;
    end else begin
      sclk_prev <= sclk_q[SYNC_N-1];
      le_prev   <= le_q[SYNC_N-1];
      if (sclk_rise) sr_q <= {sr_q[WORD_W-2:0], sdat_q[SYNC_N-1]};
    end
  end

  assign word_o = sr_q;
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import pll_cfg_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 4,
  parameter int R_W    = 12,
  parameter int GAIN_W = 4,
  parameter int ACC_W  = 4,
  parameter int R_MIN  = 3,
  localparam int DATA_W = WORD_W - ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [R_W-1:0]    if_r_o,
  output logic [GAIN_W-1:0] cp_gain_o,
  output logic [ACC_W-1:0]  access_o,
  output logic [DATA_W-1:0] r0_data_o,
  output logic              bad_r_o,
  output logic              r0_wr_o,
  output logic              pwr_wr_o
);
  localparam int R_LO = ADDR_W;
  localparam int G_LO = R_LO + R_W;
  localparam int A_LO = G_LO + GAIN_W;

  logic [ADDR_W-1:0] addr;
  logic [R_W-1:0]    new_r;
  logic              div_wr, r_ok;

  assign addr     = word_i[ADDR_W-1:0];
  assign new_r    = word_i[G_LO-1:R_LO];
  assign div_wr   = wr_i && (addr == ADDR_DIV);
  assign r0_wr_o  = wr_i && (addr == ADDR_R0);
  assign pwr_wr_o = wr_i && (addr == ADDR_PWR);
  assign r_ok     = new_r >= R_W'(R_MIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      if_r_o    <= '0;
      cp_gain_o <= '0;
      access_o  <= '0;
      r0_data_o <= '0;
      bad_r_o   <= 1'b0;
    end else begin
      if (div_wr) begin
        cp_gain_o <= word_i[A_LO-1:G_LO];
        access_o  <= word_i[A_LO+ACC_W-1:A_LO];
        bad_r_o   <= !r_ok;
        if (r_ok) if_r_o <= new_r;
      end
      if (r0_wr_o) r0_data_o <= word_i[WORD_W-1:ADDR_W];
    end
  end
endmodule

// File: rtl/power_ctrl.sv
module power_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic pwr_wr_i,
  input  logic pd_in_i,
  input  logic au_in_i,
  input  logic r0_wr_i,
  output logic pd_bit_o,
  output logic au_o,
  output logic pd_o,
  output logic cp_tri_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_bit_o <= 1'b0;
      au_o     <= 1'b0;
    end else if (pwr_wr_i) begin
      pd_bit_o <= pd_in_i;
      au_o     <= au_in_i;
    end else if (r0_wr_i && au_o) begin
      pd_bit_o <= 1'b0;
    end
  end

  // chip enable low overrides the stored bit
  assign pd_o     = !ce_i || pd_bit_o;
  assign cp_tri_o = pd_o;
endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
  import pll_cfg_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 4,
  parameter int R_W    = 12,
  parameter int GAIN_W = 4,
  parameter int ACC_W  = 4,
  parameter int R_MIN  = 3,
  parameter int SYNC_N = 2,
  localparam int DATA_W = WORD_W - ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              le_i,
  input  logic              ce_i,
  output logic [R_W-1:0]    if_r_o,
  output logic [GAIN_W-1:0] cp_gain_o,
  output logic [ACC_W-1:0]  access_o,
  output logic [DATA_W-1:0] r0_data_o,
  output logic              bad_r_o,
  output logic              pd_o,
  output logic              cp_tri_o
);
  logic [WORD_W-1:0] word;
  logic              wr_stb, r0_wr, pwr_wr, pd_bit, auto_up;

  serial_shift #(.WORD_W(WORD_W), .SYNC_N(SYNC_N)) u_shift (
    .clk_i, .rst_ni, .sclk_i, .sdata_i, .le_i,
    .word_o(word), .latch_o(wr_stb)
  );

  cfg_regs #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .R_W(R_W),
    .GAIN_W(GAIN_W), .ACC_W(ACC_W), .R_MIN(R_MIN)
  ) u_regs (
    .clk_i, .rst_ni, .wr_i(wr_stb), .word_i(word),
    .if_r_o, .cp_gain_o, .access_o, .r0_data_o, .bad_r_o,
    .r0_wr_o(r0_wr), .pwr_wr_o(pwr_wr)
  );

  power_ctrl u_pwr (
    .clk_i, .rst_ni, .ce_i,
    .pwr_wr_i(pwr_wr), .pd_in_i(word[PWR_PD_BIT]), .au_in_i(word[PWR_AU_BIT]),
    .r0_wr_i(r0_wr), .pd_bit_o(pd_bit), .au_o(auto_up),
    .pd_o, .cp_tri_o
  );
endmodule

// File: rtl/pll_cfg_chk.sv
module pll_cfg_chk #(
  parameter int R_W    = 12,
  parameter int ADDR_W = 4,
  parameter int R_MIN  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_i,
  input logic              pd_o,
  input logic              cp_tri_o,
  input logic [R_W-1:0]    if_r_o,
  input logic              bad_r_o,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              auto_up,
  input logic              pd_bit
);
  // R6
  a_r6_ce_forces_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |-> pd_o);
  // R6
  a_r6_tri_tracks_pd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_tri_o == pd_o);
  // R3
  a_r3_r_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (if_r_o == '0) || (if_r_o >= R_W'(R_MIN)));
  // R3
  a_r3_reject_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (if_r_o != $past(if_r_o)) |-> !bad_r_o);
  // R8
  a_r8_no_strobe_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb |=> $stable(if_r_o));
  // R5
  a_r5_auto_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && wr_addr == '0 && auto_up) |=> !pd_bit);
endmodule

bind pll_cfg_regs pll_cfg_chk #(.R_W(R_W), .ADDR_W(ADDR_W), .R_MIN(R_MIN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .pd_o(pd_o), .cp_tri_o(cp_tri_o),
  .if_r_o(if_r_o), .bad_r_o(bad_r_o), .wr_stb(wr_stb), .wr_addr(word[ADDR_W-1:0]),
  .auto_up(auto_up), .pd_bit(pd_bit)
);

// File: tb/sim_pll_cfg_regs.sv
module sim_pll_cfg_regs;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, le = 1'b0, ce = 1'b0;
  logic [11:0] if_r;
  logic [3:0]  gain, acc;
  logic [19:0] r0d;
  logic        bad, pd, tri_en;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pll_cfg_regs u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdata_i(sdata), .le_i(le), .ce_i(ce),
    .if_r_o(if_r), .cp_gain_o(gain), .access_o(acc), .r0_data_o(r0d),
    .bad_r_o(bad), .pd_o(pd), .cp_tri_o(tri_en)
  );

  typedef struct packed {
    logic [23:0] w;
    logic [11:0] r;
    logic [3:0]  g;
    logic [3:0]  a;
    logic        bad;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{24'hA50037, 12'h003, 4'h5, 4'hA, 1'b0},  // min legal
    '{24'h0FFFF7, 12'hFFF, 4'hF, 4'h0, 1'b0},  // max
    '{24'h210027, 12'hFFF, 4'h1, 4'h2, 1'b1},  // 2 rejected
    '{24'h330007, 12'hFFF, 4'h3, 4'h3, 1'b1},  // 0 rejected
    '{24'h9C5A37, 12'h5A3, 4'hC, 4'h9, 1'b0},
    '{24'h000047, 12'h004, 4'h0, 4'h0, 1'b0}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // R1: MSB first, one bit per rising sclk, then latch
  task automatic send_word(logic [23:0] w);
    for (int i = 23; i >= 0; i--) begin
      sclk = 1'b0; sdata = w[i];
      wait_clk(3);
      sclk = 1'b1;
      wait_clk(3);
    end
    sclk = 1'b0;
    wait_clk(3);
    le = 1'b1;
    wait_clk(4);
    le = 1'b0;
    wait_clk(3);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          n_bad++;
          $display("FAIL watchdog: got timeout expected completion");
          $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
          $finish;
        end
      end
    join_none
  end

  initial begin
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(2);
    // R7 reset state, ce low
    chk("R7 if_r", 32'(if_r), 0);
    chk("R7 gain/acc", 32'({gain, acc}), 0);
    chk("R7 r0", 32'(r0d), 0);
    chk("R7 bad", 32'(bad), 0);
    chk("R7 pd with ce low", 32'(pd), 1);
    chk("R6 tri", 32'(tri_en), 1);
    ce = 1'b1;
    wait_clk(1);
    chk("R6 pd with ce high", 32'(pd), 0);

    // R2 R3 table walk
    foreach (VECS[k]) begin
      send_word(VECS[k].w);
      chk("R2 if_r", 32'(if_r), 32'(VECS[k].r));
      chk("R2 gain", 32'(gain), 32'(VECS[k].g));
      chk("R2 access", 32'(acc), 32'(VECS[k].a));
      chk("R3 bad flag", 32'(bad), 32'(VECS[k].bad));
    end

    // R8 unused code
    send_word(24'hFFFFF5);
    chk("R8 if_r", 32'(if_r), 32'h004);
    chk("R8 gain/acc", 32'({gain, acc}), 0);
    chk("R8 r0", 32'(r0d), 0);
    chk("R8 pd", 32'(pd), 0);

    // R4 power-down stored
    send_word(24'h000011);
    chk("R4 pd set", 32'(pd), 1);
    chk("R6 tri", 32'(tri_en), 1);
    // R5 no auto-up: R0 write keeps pd, R1 payload order
    send_word(24'h123450);
    chk("R1 r0 data", 32'(r0d), 32'h12345);
    chk("R5 pd kept", 32'(pd), 1);
    // R4 pd with auto-up
    send_word(24'h000031);
    chk("R4 pd with au", 32'(pd), 1);
    send_word(24'hABCDE0);
    chk("R5 r0 data", 32'(r0d), 32'hABCDE);
    chk("R5 auto clear", 32'(pd), 0);
    // R6 ce override
    ce = 1'b0;
    wait_clk(1);
    chk("R6 ce low", 32'(pd), 1);
    chk("R6 tri ce low", 32'(tri_en), 1);
    ce = 1'b1;
    wait_clk(1);
    chk("R6 ce high", 32'(pd), 0);
    send_word(24'h000001);
    chk("R4 pd clear", 32'(pd), 0);
    chk("R8 if_r after pwr", 32'(if_r), 32'h004);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule